// File: doc/BRIEF.md
# Fixed-Head Disk Programmed-I/O Register Interface

This block is the processor-facing register front end of a controller for a head-per-track disk attached to a 12-bit minicomputer. The processor issues I/O instructions that select one of three instruction groups, each carrying a 3-bit pulse field. The block holds a 12-bit status word and a 12-bit disk address, together with a done flag and an interrupt request. It decodes each instruction against the accumulator value the processor presents. In the same cycle it returns the updated accumulator and a skip flag.

Starting a transfer raises a one-cycle start request to a separate transfer engine, along with a read or write function bit. The engine reports completion with a strobe and reports errors with set strobes. A rotation counter outside the block supplies the current angular word position and an index-mark level. The instruction strobe `iot_valid` has no ready: an instruction is accepted in every cycle in which it is high, so the processor never sees back-pressure. All other pins are plain level or strobe signals.

Top module: `fhd_iot_regs`

## Requirements
- R1: After reset the status word is 0, the disk address is 0, done is 1 and the interrupt request is 0.
- R2: Group 0 (`iot_group`=0) with pulse bit 0 clears the disk address, done, the interrupt request and the three error bits (status bits 2:0), and leaves status bits 11:3 unchanged.
- R3: Group 0 with pulse bit 1 or 2 ORs `acc_in` into the disk address after any clear from pulse bit 0. In the same cycle it drives `acc_out` to 0 and raises `start_req`. `start_write` is 1 when pulse bit 2 is set and 0 otherwise.
- R4: Group 1 with pulse bit 0 clears the extension field (status bits 10:3). Pulse bit 2 then ORs `acc_in[10:3]` into that field and ORs the status value held before the instruction into `acc_out`.
- R5: Group 1 with pulse bit 1 forces the accumulator to 0 before any OR from pulse bit 2. It skips when disk address bits 10:0 equal `rot_pos`.
- R6: Group 2 with pulse bit 0 skips when status bits 2:0 are all zero.
- R7: Group 2 with pulse bit 1 but not pulse bit 2 skips when done is 1. Pulse bit 2 ORs the disk address into the accumulator, and when pulse bit 1 is also set the accumulator is zeroed first.
- R8: `xfer_done` sets done and the interrupt request, and it wins over a clear in the same cycle. The interrupt request is never 1 while done is 0.
- R9: `err_set` bit 0 (parity), bit 1 (write lock) and bit 2 (data late) set status bits 0, 1 and 2. A set wins over a clear in the same cycle.
- R10: Status bit 11 holds the value `index_mark` had at the previous clock edge (after reset).
- R11: With `iot_valid` low or `iot_group`=3, `acc_out` equals `acc_in`, skip and start are 0, and no register changes except by R8–R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iot_valid | input | 1 | Instruction strobe, one cycle per instruction |
| iot_group | input | 2 | Instruction group select (0, 1, 2; 3 is no-op) |
| iot_pulse | input | 3 | Pulse bits of the instruction |
| acc_in | input | 12 | Accumulator value from the processor |
| rot_pos | input | 11 | Current rotational word position |
| index_mark | input | 1 | Photocell index level |
| xfer_done | input | 1 | Transfer-complete strobe from the engine |
| err_set | input | 3 | Error set strobes {data late, write lock, parity} |
| acc_out | output | 12 | Updated accumulator |
| skip | output | 1 | Skip condition |
| start_req | output | 1 | Transfer start request |
| start_write | output | 1 | Function of the start: 1 write, 0 read |
| status_out | output | 12 | Status word |
| disk_addr | output | 12 | Disk address register |
| done | output | 1 | Done flag |
| irq | output | 1 | Interrupt request |

## Verification
`acc_out`, `skip`, `start_req` and `start_write` respond combinationally in the cycle of the instruction. The bench samples them 1 ns after driving the inputs at the falling edge, before the next rising edge. The status word, disk address, done and interrupt request change at the rising edge that ends that cycle, so they are compared with the bench's model at the following falling edge. Every stimulus step therefore checks both its same-cycle results and its one-cycle-later register effects before the next stimulus is applied.

// File: rtl/fhd_pkg.sv
package fhd_pkg;
  parameter int FHD_WORD_W = 12;
  parameter int FHD_POS_W  = 11;
  parameter int FHD_ERR_W  = 3;
  parameter int FHD_EXT_W  = 8;
  parameter int FHD_GRP_W  = 2;
  parameter int FHD_PLS_W  = 3;

  localparam logic [FHD_GRP_W-1:0] GRP_CTL  = 2'd0;
  localparam logic [FHD_GRP_W-1:0] GRP_EXT  = 2'd1;
  localparam logic [FHD_GRP_W-1:0] GRP_STAT = 2'd2;

  typedef struct packed {
    logic clr_da_err;
    logic start;
    logic start_wr;
    logic clr_ext;
    logic ext_xchg;
    logic pos_chk;
    logic err_skip;
    logic done_skip;
    logic rd_da;
    logic acc_zero_da;
  } fhd_act_t;
endpackage

// File: rtl/fhd_iot_decode.sv
module fhd_iot_decode
  import fhd_pkg::*;
#(
  parameter int GRP_W = FHD_GRP_W,
  parameter int PLS_W = FHD_PLS_W
) (
  input  logic             iot_valid,
  input  logic [GRP_W-1:0] iot_group,
  input  logic [PLS_W-1:0] iot_pulse,
  output fhd_act_t         act
);
  logic p1, p2, p4;
  assign p1 = iot_pulse[0];
  assign p2 = iot_pulse[1];
  assign p4 = iot_pulse[2];

  always_comb begin
    act = '0;
    if (iot_valid) begin
      case (iot_group)
        GRP_CTL: begin
          act.clr_da_err = p1;
          act.start      = p2 | p4;
          act.start_wr   = p4;
        end
        GRP_EXT: begin
          act.clr_ext  = p1;
          act.pos_chk  = p2;
          act.ext_xchg = p4;
        end
        GRP_STAT: begin
          act.err_skip    = p1;
          act.done_skip   = p2 & ~p4;
          act.rd_da       = p4;
          act.acc_zero_da = p2 & p4;
        end
        default: act = '0;
      endcase
    end
  end
endmodule

// File: rtl/fhd_status_reg.sv
module fhd_status_reg
  import fhd_pkg::*;
#(
  parameter int WORD_W = FHD_WORD_W,
  parameter int ERR_W  = FHD_ERR_W,
  parameter int EXT_W  = FHD_EXT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_err,
  input  logic              clr_ext,
  input  logic              ld_ext,
  input  logic [EXT_W-1:0]  acc_ext,
  input  logic [ERR_W-1:0]  err_set,
  input  logic              index_mark,
  output logic [WORD_W-1:0] status
);
  localparam int EXT_LO = ERR_W;
  localparam int EXT_HI = ERR_W + EXT_W - 1;
  localparam int PC_BIT = WORD_W - 1;

  logic [EXT_W-1:0] ext_nxt;
  logic [ERR_W-1:0] err_nxt;

  always_comb begin
    ext_nxt = status[EXT_HI:EXT_LO];
    if (clr_ext) ext_nxt = '0;
    if (ld_ext)  ext_nxt = ext_nxt | acc_ext;
    err_nxt = clr_err ? '0 : status[ERR_W-1:0];
    err_nxt = err_nxt | err_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= {index_mark, ext_nxt, err_nxt};
  end

  a_r9_err_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_set) |=> ((status[ERR_W-1:0] & $past(err_set)) == $past(err_set)));

  a_r4_ext_or: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ext |=> ((status[EXT_HI:EXT_LO] & $past(acc_ext)) == $past(acc_ext)));

  a_r4_ext_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ext && !ld_ext) |=> (status[EXT_HI:EXT_LO] == '0));

  a_r10_index: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(index_mark) |=> status[PC_BIT]);
endmodule

// File: rtl/fhd_addr_reg.sv
module fhd_addr_reg
  import fhd_pkg::*;
#(
  parameter int WORD_W = FHD_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              start,
  input  logic [WORD_W-1:0] acc_in,
  input  logic              xfer_done,
  output logic [WORD_W-1:0] da,
  output logic              done,
  output logic              irq
);
  logic [WORD_W-1:0] da_nxt;

  always_comb begin
    da_nxt = clr ? '0 : da;
    if (start) da_nxt = da_nxt | acc_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      da   <= '0;
      done <= 1'b1;
      irq  <= 1'b0;
    end else begin
      da <= da_nxt;
      if (xfer_done) begin
        done <= 1'b1;
        irq  <= 1'b1;
      end else if (clr) begin
        done <= 1'b0;
        irq  <= 1'b0;
      end
    end
  end

  a_r8_irq_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done);

  a_r8_done_wins: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> (done && irq));

  a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !start && !xfer_done) |=> (da == '0 && !done && !irq));

  a_r3_addr_or: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ((da & $past(acc_in)) == $past(acc_in)));
endmodule

// File: rtl/fhd_iot_regs.sv
module fhd_iot_regs
  import fhd_pkg::*;
#(
  parameter int WORD_W = FHD_WORD_W,
  parameter int POS_W  = FHD_POS_W,
  parameter int ERR_W  = FHD_ERR_W,
  parameter int EXT_W  = FHD_EXT_W,
  parameter int GRP_W  = FHD_GRP_W,
  parameter int PLS_W  = FHD_PLS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iot_valid,
  input  logic [GRP_W-1:0]  iot_group,
  input  logic [PLS_W-1:0]  iot_pulse,
  input  logic [WORD_W-1:0] acc_in,
  input  logic [POS_W-1:0]  rot_pos,
  input  logic              index_mark,
  input  logic              xfer_done,
  input  logic [ERR_W-1:0]  err_set,
  output logic [WORD_W-1:0] acc_out,
  output logic              skip,
  output logic              start_req,
  output logic              start_write,
  output logic [WORD_W-1:0] status_out,
  output logic [WORD_W-1:0] disk_addr,
  output logic              done,
  output logic              irq
);
  localparam int EXT_LO = ERR_W;
  localparam int EXT_HI = ERR_W + EXT_W - 1;

  fhd_act_t act;

  fhd_iot_decode #(.GRP_W(GRP_W), .PLS_W(PLS_W)) u_dec (
    .iot_valid (iot_valid),
    .iot_group (iot_group),
    .iot_pulse (iot_pulse),
    .act       (act)
  );

  fhd_status_reg #(.WORD_W(WORD_W), .ERR_W(ERR_W), .EXT_W(EXT_W)) u_sta (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_err    (act.clr_da_err),
    .clr_ext    (act.clr_ext),
    .ld_ext     (act.ext_xchg),
    .acc_ext    (acc_in[EXT_HI:EXT_LO]),
    .err_set    (err_set),
    .index_mark (index_mark),
    .status     (status_out)
  );

  fhd_addr_reg #(.WORD_W(WORD_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (act.clr_da_err),
    .start     (act.start),
    .acc_in    (acc_in),
    .xfer_done (xfer_done),
    .da        (disk_addr),
    .done      (done),
    .irq       (irq)
  );

  always_comb begin
    acc_out = acc_in;
    if (act.start || act.pos_chk || act.acc_zero_da) acc_out = '0;
    if (act.ext_xchg) acc_out = acc_out | status_out;
    if (act.rd_da)    acc_out = acc_out | disk_addr;
  end

  always_comb begin
    skip = 1'b0;
    if (act.pos_chk && (disk_addr[POS_W-1:0] == rot_pos)) skip = 1'b1;
    if (act.err_skip && (status_out[ERR_W-1:0] == '0))  skip = 1'b1;
    if (act.done_skip && done)                          skip = 1'b1;
  end

  assign start_req   = act.start;
  assign start_write = act.start_wr;

  a_r3_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |-> (acc_out == '0));

  a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!iot_valid) |-> (acc_out == acc_in && !skip && !start_req));

  a_r11_idle_regs: assert property (@(posedge clk) disable iff (!rst_n)
    (!iot_valid) |=> $stable(disk_addr));
endmodule

// File: tb/fhd_iot_regs_bench.sv
`timescale 1ns/1ps
module fhd_iot_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        iot_valid;
  logic [1:0]  iot_group;
  logic [2:0]  iot_pulse;
  logic [11:0] acc_in;
  logic [10:0] rot_pos;
  logic        index_mark;
  logic        xfer_done;
  logic [2:0]  err_set;
  logic [11:0] acc_out;
  logic        skip, start_req, start_write;
  logic [11:0] status_out, disk_addr;
  logic        done, irq;

  always #2 clk = ~clk;

  fhd_iot_regs u_fhd_iot_regs (
    .clk(clk), .rst_n(rst_n), .iot_valid(iot_valid), .iot_group(iot_group),
    .iot_pulse(iot_pulse), .acc_in(acc_in), .rot_pos(rot_pos),
    .index_mark(index_mark), .xfer_done(xfer_done), .err_set(err_set),
    .acc_out(acc_out), .skip(skip), .start_req(start_req),
    .start_write(start_write), .status_out(status_out), .disk_addr(disk_addr),
    .done(done), .irq(irq)
  );

  int checks = 0;
  int fails  = 0;
  logic [11:0] m_sta, m_da;
  logic        m_done, m_irq;
  logic [11:0] e_acc;
  logic        e_skip, e_st, e_wr;

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string comb_tag(input logic v, input logic [1:0] g);
    if (!v || g == 2'd3) return "R11";
    case (g)
      2'd0: return "R3";
      2'd1: return "R5";
      default: return "R7";
    endcase
  endfunction

  // Predict combinational results and next register state from the requirements.
  task automatic predict(input logic v, input logic [1:0] g, input logic [2:0] p,
                         input logic [11:0] a, input logic [10:0] rot,
                         input logic xd, input logic [2:0] es, input logic idx,
                         output logic [11:0] n_sta, output logic [11:0] n_da,
                         output logic n_done, output logic n_irq);
    e_acc = a; e_skip = 1'b0; e_st = 1'b0; e_wr = 1'b0;
    n_sta = m_sta; n_da = m_da; n_done = m_done; n_irq = m_irq;
    if (v) begin
      if (g == 2'd0) begin
        if (p[0]) begin n_da = '0; n_done = 1'b0; n_irq = 1'b0; n_sta[2:0] = '0; end
        if (p[1] | p[2]) begin n_da = n_da | a; e_st = 1'b1; e_wr = p[2]; e_acc = '0; end
      end else if (g == 2'd1) begin
        if (p[0]) n_sta[10:3] = '0;
        if (p[1]) begin e_acc = '0; e_skip = (m_da[10:0] == rot); end
        if (p[2]) begin n_sta[10:3] = n_sta[10:3] | a[10:3]; e_acc = e_acc | m_sta; end
      end else if (g == 2'd2) begin
        if (p[0] && m_sta[2:0] == 3'b000) e_skip = 1'b1;
        if (p[1] && !p[2] && m_done) e_skip = 1'b1;
        if (p[2]) e_acc = (p[1] ? 12'h000 : e_acc) | m_da;
      end
    end
    n_sta[2:0] = n_sta[2:0] | es;
    n_sta[11]  = idx;
    if (xd) begin n_done = 1'b1; n_irq = 1'b1; end
  endtask

  // Caller is at a falling edge; drive, check same-cycle outputs, then registers one edge later.
  task automatic step(input logic v, input logic [1:0] g, input logic [2:0] p,
                      input logic [11:0] a, input logic [10:0] rot,
                      input logic xd, input logic [2:0] es, input logic idx);
    logic [11:0] n_sta, n_da;
    logic n_done, n_irq;
    string t;
    iot_valid = v; iot_group = g; iot_pulse = p; acc_in = a; rot_pos = rot;
    xfer_done = xd; err_set = es; index_mark = idx;
    #1;
    predict(v, g, p, a, rot, xd, es, idx, n_sta, n_da, n_done, n_irq);
    t = comb_tag(v, g);
    chk({t, " acc_out"}, acc_out, e_acc);
    chk((v && g == 2'd2) ? "R6 skip" : {t, " skip"}, {11'd0, skip}, {11'd0, e_skip});
    chk("R3 start_req", {11'd0, start_req}, {11'd0, e_st});
    if (e_st) chk("R3 start_write", {11'd0, start_write}, {11'd0, e_wr});
    m_sta = n_sta; m_da = n_da; m_done = n_done; m_irq = n_irq;
    @(negedge clk);
    chk("R2 R9 error bits", {9'd0, status_out[2:0]}, {9'd0, m_sta[2:0]});
    chk("R4 extension field", {4'd0, status_out[10:3]}, {4'd0, m_sta[10:3]});
    chk("R10 index bit", {11'd0, status_out[11]}, {11'd0, m_sta[11]});
    chk("R3 disk address", disk_addr, m_da);
    chk("R8 done", {11'd0, done}, {11'd0, m_done});
    chk("R8 irq", {11'd0, irq}, {11'd0, m_irq});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    seed = $urandom(32'd4242);
    rst_n = 1'b0; iot_valid = 1'b0; iot_group = '0; iot_pulse = '0; acc_in = '0;
    rot_pos = '0; index_mark = 1'b0; xfer_done = 1'b0; err_set = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 status", status_out, 12'h000);
    chk("R1 disk address", disk_addr, 12'h000);
    chk("R1 done", {11'd0, done}, 12'h001);
    chk("R1 irq", {11'd0, irq}, 12'h000);
    m_sta = '0; m_da = '0; m_done = 1'b1; m_irq = 1'b0;
    @(negedge clk);
    // Directed corner cases
    step(1, 2'd2, 3'b010, 12'h555, 11'd0, 0, 3'b000, 0);   // R7 skip on done
    step(1, 2'd0, 3'b100, 12'h123, 11'd0, 0, 3'b000, 1);   // R3 write start
    step(1, 2'd0, 3'b010, 12'h404, 11'd0, 0, 3'b000, 1);   // R3 read start, OR
    step(1, 2'd1, 3'b010, 12'hFFF, 11'h527, 0, 3'b000, 0); // R5 position match
    step(1, 2'd1, 3'b010, 12'hFFF, 11'h526, 0, 3'b000, 0); // R5 mismatch
    step(1, 2'd1, 3'b100, 12'h7F8, 11'd0, 0, 3'b000, 0);   // R4 load extension
    step(1, 2'd1, 3'b101, 12'h0A8, 11'd0, 0, 3'b000, 0);   // R4 clear then load
    step(1, 2'd1, 3'b110, 12'hFFF, 11'h527, 0, 3'b000, 0); // R5 zero then OR status
    step(1, 2'd2, 3'b110, 12'hABC, 11'd0, 0, 3'b000, 0);   // R7 zero then OR address
    step(1, 2'd2, 3'b100, 12'h800, 11'd0, 0, 3'b000, 0);   // R7 OR address
    step(0, 2'd0, 3'b000, 12'h000, 11'd0, 0, 3'b101, 0);   // R9 error set
    step(1, 2'd2, 3'b001, 12'h000, 11'd0, 0, 3'b000, 0);   // R6 no skip with error
    step(1, 2'd0, 3'b001, 12'h000, 11'd0, 1, 3'b010, 0);   // R8 R9 set wins over clear
    step(1, 2'd0, 3'b001, 12'h000, 11'd0, 0, 3'b000, 0);   // R2 clear
    step(1, 2'd2, 3'b001, 12'h000, 11'd0, 0, 3'b000, 0);   // R6 skip, no errors
    step(1, 2'd2, 3'b010, 12'h000, 11'd0, 0, 3'b000, 0);   // R7 no skip, done low
    step(1, 2'd3, 3'b111, 12'h9C3, 11'd0, 0, 3'b000, 1);   // R11 group 3 no-op
    step(0, 2'd0, 3'b111, 12'h3C9, 11'd0, 0, 3'b000, 0);   // R11 not valid
    // Constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic v, xd, idx;
      logic [1:0] g;
      logic [2:0] p, es;
      logic [11:0] a;
      logic [10:0] rot;
      v   = ($urandom % 10) < 7;
      g   = 2'($urandom);
      p   = 3'($urandom);
      a   = 12'($urandom);
      rot = (($urandom % 4) == 0) ? m_da[10:0] : 11'($urandom);
      xd  = ($urandom % 10) == 0;
      es  = (($urandom % 8) == 0) ? 3'($urandom) : 3'b000;
      idx = 1'($urandom);
      step(v, g, p, a, rot, xd, es, idx);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule